// File: doc/BRIEF.md
# Segmented Racing Magnitude Comparator

This block compares two wide unsigned operands by cutting them into 8-bit slices and racing every slice at the same time. Each slice first clears the bit positions where both operands hold a 1. It then walks its bits from the top, one bit per clock. The first remaining 1 that it meets settles that slice in favour of the operand that owns it. A slice that finds no such 1 reports a draw.

When every slice has finished, a combinational selection tree merges the slice verdicts. A more significant slice always wins over a less significant one. The tree looks at a lower slice only when everything above it is a draw. The block has one start/done handshake for the full width. A 32-bit default uses four slices and two tree levels. A 64-bit build uses eight slices and three levels.

The caller pulses `start` while the block is idle and waits for the one-cycle `done` pulse. It then reads exactly one of `a_gt_b`, `a_lt_b` and `a_eq_b`. The verdict stays on the outputs until the next accepted start.

Top module: `seg_race_cmp`

## Requirements
- R1: Bit positions where both operands hold 1 are cleared before the race, so they never decide a slice. Two operands that differ only below a common prefix of ones are ordered by the differing bits alone.
- R2: Within a slice, the most significant bit position where exactly one operand holds 1 decides the slice in favour of that operand.
- R3: A slice whose two operand bytes are equal reports a draw.
- R4: The verdict of the most significant slice that is not a draw is the final result, whatever the lower slices report.
- R5: When all slices above a slice are draws, that slice decides. The result is equal only when every slice is a draw.
- R6: `done` is high for exactly one cycle. It rises in the cycle that follows the 8th rising clock edge after the edge that sampled the accepted `start`.
- R7: While `done` is high, exactly one of `a_gt_b`, `a_lt_b`, `a_eq_b` is high. `a_gt_b` means a > b and `a_lt_b` means a < b.
- R8: A `start` that arrives while a comparison is running has no effect: neither the running result nor the timing of `done` changes.
- R9: After `done`, the result outputs hold their value until the next accepted `start`. A `start` in the same cycle as `done` is accepted.
- R10: After reset, `done` is low and `a_eq_b` is high.
- R11: WIDTH must be a power-of-two multiple of 8. A 64-bit build has eight slices and orders operands by the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a comparison when the block is idle |
| a | input | WIDTH | Operand A, unsigned; sampled with start |
| b | input | WIDTH | Operand B, unsigned; sampled with start |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| a_gt_b | output | 1 | A is greater than B |
| a_lt_b | output | 1 | A is less than B |
| a_eq_b | output | 1 | A equals B |

## Verification
Two events can fall in the same cycle: the completion pulse of one comparison and the acceptance of the next `start`. The bench provokes this by raising `start` with fresh operands in exactly the cycle where `done` is high. It judges the first verdict in that cycle, and then requires the second verdict to arrive after the full race latency. A second overlap is also tested: a `start` injected while a race is running must leave both the verdict and the timing of `done` unchanged. Every expected verdict comes from plain integer comparison of the operands in the bench.

// File: rtl/segcmp_pkg.sv
package segcmp_pkg;

  typedef enum logic [1:0] {
    RES_DRAW = 2'b00,
    RES_GT   = 2'b01,
    RES_LT   = 2'b10
  } res_t;

  // Clear positions where both operands hold 1 (R1)
  function automatic logic [1:0] pre_encode(input logic abit, input logic bbit);
    return {abit & ~bbit, ~abit & bbit};
  endfunction

  // Two win flags: both high means nothing was decided
  function automatic res_t flags_to_res(input logic win_a, input logic win_b);
    if (win_a && win_b) return RES_DRAW;
    if (win_a)          return RES_GT;
    if (win_b)          return RES_LT;
    return RES_DRAW;
  endfunction

  // The more significant input wins unless it is a draw (R4, R5)
  function automatic res_t merge_res(input res_t hi, input res_t lo);
    return (hi == RES_DRAW) ? lo : hi;
  endfunction

endpackage

// File: rtl/race_segment.sv
module race_segment
  import segcmp_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEG_W-1:0] a_seg,
  input  logic [SEG_W-1:0] b_seg,
  output logic             busy,
  output logic             done,
  output logic             win_a,
  output logic             win_b
);
  localparam int CW = (SEG_W > 1) ? $clog2(SEG_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEG_W - 1);

  logic [SEG_W-1:0] enc_a, enc_b;
  logic [SEG_W-1:0] pa_q, pb_q;
  logic [CW-1:0]    cnt_q;
  logic             decided_q;
  logic [CW-1:0]    bit_idx;
  logic             hit_a, hit_b, accept;

  for (genvar i = 0; i < SEG_W; i++) begin : g_enc
    assign {enc_a[i], enc_b[i]} = pre_encode(a_seg[i], b_seg[i]);
  end

  assign bit_idx = LAST - cnt_q;
  assign accept  = start && !busy;
  assign hit_a   = busy && !decided_q && pa_q[bit_idx];
  assign hit_b   = busy && !decided_q && pb_q[bit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cnt_q     <= '0;
      decided_q <= 1'b0;
      win_a     <= 1'b1;
      win_b     <= 1'b1;
      pa_q      <= '0;
      pb_q      <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        cnt_q     <= '0;
        decided_q <= 1'b0;
        win_a     <= 1'b1;
        win_b     <= 1'b1;
        pa_q      <= enc_a;
        pb_q      <= enc_b;
      end else if (busy) begin
        if (hit_a) begin
          win_b     <= 1'b0;
          decided_q <= 1'b1;
        end else if (hit_b) begin
          win_a     <= 1'b0;
          decided_q <= 1'b1;
        end
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R1: after pre-encoding, no position is claimed by both operands
  p_preenc_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_a && hit_b));

  // R2: once a slice is decided, exactly one flag stays up
  p_flags_never_both_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!win_a && !win_b));

  // R2: a decided slice keeps its verdict until the race ends
  p_verdict_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && decided_q) |=> ($stable(win_a) && $stable(win_b)));

  // R6: the completion pulse lasts one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a running race is not restarted
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/prio_tree.sv
module prio_tree
  import segcmp_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic [2*NSEG-1:0] leaf_flat,  // leaf j at [2j+:2], j = 0 is the most significant slice
  output res_t              root
);
  res_t heap [1:2*NSEG-1];

  for (genvar j = 0; j < NSEG; j++) begin : g_leaf
    assign heap[NSEG+j] = res_t'(leaf_flat[2*j +: 2]);
  end

  for (genvar n = 1; n < NSEG; n++) begin : g_node
    assign heap[n] = merge_res(heap[2*n], heap[2*n+1]);
  end

  assign root = heap[1];
endmodule

// File: rtl/seg_race_cmp.sv
module seg_race_cmp
  import segcmp_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             done,
  output logic             a_gt_b,
  output logic             a_lt_b,
  output logic             a_eq_b
);
  localparam int NSEG = WIDTH / SEG_W;

  if ((WIDTH % SEG_W) != 0 || NSEG < 1 || (NSEG & (NSEG - 1)) != 0) begin : g_bad_width
    initial $error("seg_race_cmp: WIDTH must be a power-of-two multiple of SEG_W");
  end

  logic [NSEG-1:0]   seg_done, seg_busy, seg_wa, seg_wb;
  logic [2*NSEG-1:0] leaf_flat;
  res_t              root;
  res_t              top_leaf;
  logic              any_busy, leaves_all_draw;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    race_segment #(.SEG_W(SEG_W)) u_seg (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .a_seg (a[i*SEG_W +: SEG_W]),
      .b_seg (b[i*SEG_W +: SEG_W]),
      .busy  (seg_busy[i]),
      .done  (seg_done[i]),
      .win_a (seg_wa[i]),
      .win_b (seg_wb[i])
    );
    assign leaf_flat[2*(NSEG-1-i) +: 2] = flags_to_res(seg_wa[i], seg_wb[i]);
  end

  prio_tree #(.NSEG(NSEG)) u_tree (
    .leaf_flat (leaf_flat),
    .root      (root)
  );

  assign done     = &seg_done;
  assign any_busy = |seg_busy;
  assign a_gt_b   = (root == RES_GT);
  assign a_lt_b   = (root == RES_LT);
  assign a_eq_b   = (root == RES_DRAW);

  assign top_leaf        = res_t'(leaf_flat[1:0]);
  assign leaves_all_draw = (leaf_flat == '0);

  // R6: slices started together finish together
  p_done_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|seg_done) |-> (&seg_done));

  // R7: one verdict at completion
  p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({a_gt_b, a_lt_b, a_eq_b}) == 1));

  // R4: a decided top slice fixes the final verdict
  p_msb_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (top_leaf != RES_DRAW) |-> (root == top_leaf));

  // R5: equality only when every slice draws
  p_eq_all_draw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (root == RES_DRAW) |-> leaves_all_draw);

  // R9: idle outputs hold until a start is taken
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_busy && !start) |=> ($stable(a_gt_b) && $stable(a_lt_b) && $stable(a_eq_b)));

endmodule

// File: tb/seg_race_cmp_bench.sv
module seg_race_cmp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [63:0] a64 = '0, b64 = '0;
  logic done, gt, lt, eq;
  logic done64, gt64, lt64, eq64;
  int   n_chk = 0, n_fail = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;  // 50 MHz

  seg_race_cmp u_seg_race_cmp (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .done(done), .a_gt_b(gt), .a_lt_b(lt), .a_eq_b(eq));

  seg_race_cmp #(.WIDTH(64)) u_seg_race_cmp_w64 (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a64), .b(b64),
    .done(done64), .a_gt_b(gt64), .a_lt_b(lt64), .a_eq_b(eq64));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expect32(input logic [31:0] x, input logic [31:0] y);
    return {x > y, x < y, x == y};
  endfunction

  function automatic logic [2:0] expect64(input logic [63:0] x, input logic [63:0] y);
    return {x > y, x < y, x == y};
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic check_verdict(input string req, input logic [31:0] xa, input logic [31:0] xb,
                               input logic [63:0] ya, input logic [63:0] yb);
    chk({gt, lt, eq} == expect32(xa, xb), req, {61'd0, gt, lt, eq}, {61'd0, expect32(xa, xb)});
    chk({gt64, lt64, eq64} == expect64(ya, yb), {req, "/R11"},
        {61'd0, gt64, lt64, eq64}, {61'd0, expect64(ya, yb)});
  endtask

  // Launch at a negedge; returns at the negedge where done is seen.
  task automatic launch_and_wait(input logic [31:0] xa, input logic [31:0] xb,
                                 input logic [63:0] ya, input logic [63:0] yb,
                                 input int inject_at, output int lat);
    a = xa; b = xb; a64 = ya; b64 = yb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      lat++;
      if (lat == inject_at) begin
        start = 1'b1; a = ~xa; b = ~xb; a64 = ~ya; b64 = ~yb;
      end
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] xa, input logic [31:0] xb,
                        input logic [63:0] ya, input logic [63:0] yb);
    int lat;
    launch_and_wait(xa, xb, ya, yb, 0, lat);
    chk(lat == 8 && done64, "R6 latency", 64'(lat), 64'd8);
    check_verdict(req, xa, xb, ya, yb);
    chk($countones({gt, lt, eq}) == 1, "R7 one verdict", {61'd0, gt, lt, eq}, 64'd1);
    @(negedge clk);
    chk(!done, "R6 single pulse", {63'd0, done}, 64'd0);
    check_verdict("R9 hold", xa, xb, ya, yb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!done && eq && !gt && !lt, "R10 reset", {60'd0, done, gt, lt, eq}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 equal operands, R5 all-draw gives equality
    run_op("R3 equal", 32'hA5A5_5A5A, 32'hA5A5_5A5A, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
    run_op("R5 zero", 32'h0, 32'h0, 64'h0, 64'h0);
    run_op("R5 last bit", 32'h1, 32'h0, 64'h0, 64'h1);
    // R1 common ones above the differing bit
    run_op("R1 shared ones", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FF0F);
    // R4 top slice overrides opposite lower slices
    run_op("R4 priority", 32'h0100_0000, 32'h00FF_FFFF, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);

    // R2 / R5 single-bit sweep over every position
    for (int p = 0; p < 32; p++) begin
      rng = next_rng(rng);
      run_op("R2 bit sweep", rng, rng ^ (32'd1 << p), {rng, rng}, {rng, rng} ^ (64'd1 << (2 * p)));
    end

    // Random pairs with mutations confined to one slice, so higher slices draw (R5)
    for (int t = 0; t < 150; t++) begin
      logic [31:0] base, mask;
      rng = next_rng(rng); base = rng;
      rng = next_rng(rng); mask = (rng & 32'hFF) << (8 * (t % 4));
      run_op("R5 fall-through", base, base ^ mask, {base, ~base}, {base, ~base ^ {mask, mask}});
    end

    // R8 start while running is ignored
    launch_and_wait(32'h0000_1000, 32'h0000_0FFF, 64'h5, 64'h6, 3, lat);
    chk(lat == 8, "R8 timing", 64'(lat), 64'd8);
    check_verdict("R8 verdict", 32'h0000_1000, 32'h0000_0FFF, 64'h5, 64'h6);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(!done, "R8 no second done", {63'd0, done}, 64'd0);
    end

    // R9 start in the same cycle as done is accepted
    launch_and_wait(32'h10, 32'h20, 64'h30, 64'h20, 0, lat);
    check_verdict("R9 first", 32'h10, 32'h20, 64'h30, 64'h20);
    launch_and_wait(32'h2000_0000, 32'h1FFF_FFFF, 64'h1, 64'h1, 0, lat);
    chk(lat == 8, "R9 back-to-back latency", 64'(lat), 64'd8);
    check_verdict("R9 second", 32'h2000_0000, 32'h1FFF_FFFF, 64'h1, 64'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule